// File: doc/BRIEF.md
# Interrupt Enable and Flag Controller

This block is the interrupt control point of a small 8-bit processor core. A single 8-bit control register, reachable from the processor bus, holds five enable bits and three sticky event flags. The three event sources are a timer overflow pulse, an external interrupt pulse, and a 4-bit input nibble watched for any change. A fourth request, already gathered from the peripheral group, enters without a flag of its own. The block merges the flags, their enables, the peripheral-group gate and a global gate into one interrupt request line for the core.

Flags record events whether or not anything is enabled, so software can poll them. Software clears a flag by writing 0 to it. The register appears at four bus addresses that differ only in the two upper address bits, so it can be reached from any of four register banks. Reads are combinational. Writes land on the clock edge where the write strobe and an address match coincide.

Top module: `irq_enable_ctl`

## Requirements
- R1: While reset is high and after it is released, bits 7 to 1 of the register read as 0 and `irq` is 0. Bit 0 is not initialised by reset.
- R2: The register is read and written at addresses 0x00B, 0x08B, 0x10B and 0x18B, all of which reach the same storage. A write to any other address leaves the register unchanged, and a read from any other address returns 0.
- R3: A one-cycle `tmr_ovf` pulse sets bit 2 (timer flag) on that clock edge, whatever the enable bits hold.
- R4: A one-cycle `ext_evt` pulse sets bit 1 (external flag) on that clock edge, whatever the enable bits hold.
- R5: Bit 0 (port-change flag) is set on any clock edge where `port_in` differs from the value it had at the previous edge. A port that holds steady sets nothing.
- R6: Hardware never clears a flag. A set flag stays set until a bus write puts 0 in its bit.
- R7: When an event and a bus write of 0 hit the same flag on the same edge, the flag ends up set.
- R8: With bit 7 (global enable) set, `irq` is high whenever some flag and its own enable are both 1. The pairs are bit 5 with bit 2, bit 4 with bit 1, and bit 3 with bit 0.
- R9: `periph_req` raises `irq` only when bit 6 (peripheral enable) and bit 7 are both 1.
- R10: With bit 7 at 0, `irq` stays 0 whatever the flags, the enables and `periph_req` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 9 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when the address does not match |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_evt | input | 1 | External interrupt pulse |
| port_in | input | 4 | Watched port nibble |
| periph_req | input | 1 | Gathered peripheral interrupt request |
| irq | output | 1 | Interrupt request to the core |

## Verification
Two things can meet on one clock edge: a hardware event setting a flag and a software write of 0 to that same flag. The bench provokes this for all three flags. It raises the timer pulse, the external pulse or a change on the port nibble in the same cycle as a write of 0x00. It then reads the register back and expects the flag set and every other bit cleared.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 9;
    localparam int OFS_W    = 7;
    localparam int REG_OFS  = 'h0B;
    localparam int NIB_W    = 4;

    typedef struct packed {
        logic gen;
        logic pen;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_fl;
        logic ext_fl;
        logic chg_fl;
    } ctrl_t;

    typedef struct packed {
        logic tmr;
        logic ext;
        logic chg;
    } evt_t;

    function automatic logic req_combine(input ctrl_t c, input logic periph);
        logic any;
        any = (c.tmr_en & c.tmr_fl)
            | (c.ext_en & c.ext_fl)
            | (c.chg_en & c.chg_fl)
            | (c.pen & periph);
        return c.gen & any;
    endfunction

endpackage

// File: rtl/irq_addr_match.sv
module irq_addr_match #(
    parameter int ADDR_W  = irq_ctl_pkg::ADDR_W,
    parameter int OFS_W   = irq_ctl_pkg::OFS_W,
    parameter int REG_OFS = irq_ctl_pkg::REG_OFS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int BANK_W = ADDR_W - OFS_W;
    localparam int N_BANK = 1 << BANK_W;

    logic [N_BANK-1:0] bank_hit;

    for (genvar k = 0; k < N_BANK; k++) begin : g_bank
        localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(k);
        localparam logic [OFS_W-1:0]  OFS_V   = OFS_W'(REG_OFS);
        assign bank_hit[k] = (addr == {BANK_ID, OFS_V});
    end

    assign hit = |bank_hit;

endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int W = irq_ctl_pkg::NIB_W
) (
    input  logic         clk,
    input  logic [W-1:0] port_in,
    output logic         changed
);
    logic [W-1:0] last_q;

    // Reference copy follows the port every cycle, reset included, so the
    // first cycle out of reset sees no false change.
    always_ff @(posedge clk) begin
        last_q <= port_in;
    end

    assign changed = |(port_in ^ last_q);

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  ctrl_t wdata,
    input  evt_t  evt,
    output ctrl_t q
);
    logic [6:0] upper_q;
    logic       chg_q;
    ctrl_t      wr_view;
    ctrl_t      cur;
    ctrl_t      nxt;

    assign cur = ctrl_t'({upper_q, chg_q});

    always_comb begin
        wr_view = wr_hit ? wdata : cur;
        nxt        = wr_view;
        nxt.tmr_fl = wr_view.tmr_fl | evt.tmr;
        nxt.ext_fl = wr_view.ext_fl | evt.ext;
        nxt.chg_fl = wr_view.chg_fl | evt.chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else begin
            upper_q <= nxt[7:1];
        end
    end

    // Port-change flag has no reset value.
    always_ff @(posedge clk) begin
        if (!rst) begin
            chg_q <= nxt.chg_fl;
        end
    end

    assign q = cur;

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
    import irq_ctl_pkg::*;
#(
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_OFS_W   = OFS_W,
    parameter int P_REG_OFS = REG_OFS,
    parameter int P_NIB_W   = NIB_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                tmr_ovf,
    input  logic                ext_evt,
    input  logic [P_NIB_W-1:0]  port_in,
    input  logic                periph_req,
    output logic                irq
);
    logic  addr_hit;
    logic  wr_hit;
    logic  port_chg;
    evt_t  evt;
    ctrl_t ctrl_q;

    irq_addr_match #(
        .ADDR_W (P_ADDR_W),
        .OFS_W  (P_OFS_W),
        .REG_OFS(P_REG_OFS)
    ) u_match (
        .addr(bus_addr),
        .hit (addr_hit)
    );

    irq_port_watch #(.W(P_NIB_W)) u_watch (
        .clk    (clk),
        .port_in(port_in),
        .changed(port_chg)
    );

    assign wr_hit = bus_wr & addr_hit;

    always_comb begin
        evt.tmr = tmr_ovf;
        evt.ext = ext_evt;
        evt.chg = port_chg;
    end

    irq_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(wr_hit),
        .wdata (ctrl_t'(bus_wdata)),
        .evt   (evt),
        .q     (ctrl_q)
    );

    assign bus_rdata = addr_hit ? DATA_W'(ctrl_q) : '0;
    assign irq       = req_combine(ctrl_q, periph_req);

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tmr_ovf,
    input logic       ext_evt,
    input logic [3:0] port_in,
    input logic       periph_req,
    input logic       irq,
    input logic       wr_hit,
    input logic [7:0] wdata,
    input logic [7:0] ctrl
);
    // R3
    tmr_set_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> ctrl[2]);

    // R4
    ext_set_chk: assert property (@(posedge clk) disable iff (rst)
        ext_evt |=> ctrl[1]);

    // R5
    chg_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_in) |=> ctrl[0]);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ((ctrl[2:0] & $past(ctrl[2:0])) == $past(ctrl[2:0])));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_ovf && wr_hit && !wdata[2]) |=> ctrl[2]);

    // R9
    periph_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl[7] && ctrl[6] && periph_req) |-> irq);

    // R10
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl[7] |-> !irq);

endmodule

bind irq_enable_ctl irq_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_ovf   (tmr_ovf),
    .ext_evt   (ext_evt),
    .port_in   (port_in),
    .periph_req(periph_req),
    .irq       (irq),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata),
    .ctrl      (ctrl_q)
);

// File: tb/test_irq_enable_ctl.sv
module test_irq_enable_ctl;

    logic       clk = 0;
    logic       rst = 1;
    logic [8:0] bus_addr = 9'h00B;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       tmr_ovf = 0;
    logic       ext_evt = 0;
    logic [3:0] port_in = 4'h5;
    logic       periph_req = 0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_enable_ctl i_irq_enable_ctl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
        .ext_evt(ext_evt), .port_in(port_in), .periph_req(periph_req), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        tick();
        bus_wr = 0; bus_addr = 9'h00B;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 9'h00B;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst = 1;
        repeat (3) tick();
        rd(9'h00B, d);
        check("R1 in reset", d & 8'hFE, 8'h00);
        rst = 0;
        tick();
        rd(9'h00B, d);
        check("R1 after reset", d & 8'hFE, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        wr(9'h00B, 8'h00);
    endtask

    task automatic t_mirror();
        logic [7:0] d;
        logic [8:0] addrs [4] = '{9'h00B, 9'h08B, 9'h10B, 9'h18B};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            v = 8'(((i + 1) * 8'h28) & 8'h78);
            wr(addrs[i], v);
            for (int j = 0; j < 4; j++) begin
                rd(addrs[j], d);
                check("R2 mirror", d, v);
            end
        end
        wr(9'h00B, 8'h18);
        wr(9'h00C, 8'h60);
        rd(9'h00B, d);
        check("R2 other addr write ignored", d, 8'h18);
        wr(9'h04B, 8'h60);
        rd(9'h18B, d);
        check("R2 near addr write ignored", d, 8'h18);
        rd(9'h00C, d);
        check("R2 other addr reads 0", d, 8'h00);
        wr(9'h00B, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        repeat (4) tick();
        rd(9'h00B, d);
        check("R5 steady port", d, 8'h00);
        tmr_ovf = 1; tick(); tmr_ovf = 0;
        rd(9'h00B, d);
        check("R3 timer flag", d, 8'h04);
        check("R10 irq gated", {7'd0, irq}, 8'h00);
        ext_evt = 1; tick(); ext_evt = 0;
        rd(9'h00B, d);
        check("R4 ext flag", d, 8'h06);
        port_in = 4'h4; tick();
        rd(9'h00B, d);
        check("R5 port change", d, 8'h07);
        repeat (5) tick();
        rd(9'h00B, d);
        check("R6 sticky", d, 8'h07);
        wr(9'h00B, 8'h05);
        rd(9'h00B, d);
        check("R6 clear ext only", d, 8'h05);
        wr(9'h10B, 8'h00);
        rd(9'h00B, d);
        check("R6 clear all", d, 8'h00);
        port_in = 4'hC; tick();
        rd(9'h00B, d);
        check("R5 upper bit change", d, 8'h01);
        wr(9'h00B, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(9'h00B, 8'hA0);
        check("R8 timer enabled no flag", {7'd0, irq}, 8'h00);
        tmr_ovf = 1; tick(); tmr_ovf = 0;
        check("R8 timer irq", {7'd0, irq}, 8'h01);
        wr(9'h00B, 8'h90);
        check("R8 ext enabled no flag", {7'd0, irq}, 8'h00);
        ext_evt = 1; tick(); ext_evt = 0;
        check("R8 ext irq", {7'd0, irq}, 8'h01);
        wr(9'h00B, 8'h88);
        port_in = 4'hD; tick();
        check("R8 port irq", {7'd0, irq}, 8'h01);
        wr(9'h00B, 8'h3F);
        check("R10 global off", {7'd0, irq}, 8'h00);
        periph_req = 1;
        wr(9'h00B, 8'hC0);
        check("R9 periph pass", {7'd0, irq}, 8'h01);
        wr(9'h00B, 8'h80);
        check("R9 periph gated", {7'd0, irq}, 8'h00);
        wr(9'h00B, 8'h40);
        check("R10 periph global off", {7'd0, irq}, 8'h00);
        periph_req = 0;
        wr(9'h00B, 8'h00);
        rd(9'h00B, d);
        check("R6 cleared before collide", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        tmr_ovf = 1; wr(9'h00B, 8'h00); tmr_ovf = 0;
        rd(9'h00B, d);
        check("R7 timer set wins", d, 8'h04);
        ext_evt = 1; wr(9'h08B, 8'h00); ext_evt = 0;
        rd(9'h00B, d);
        check("R7 ext set wins", d, 8'h02);
        port_in = 4'h2; wr(9'h18B, 8'h00);
        rd(9'h00B, d);
        check("R7 port set wins", d, 8'h01);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mirror();
                t_flags();
                t_irq();
                t_collide();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual timeout expected finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule